// File: doc/BRIEF.md
# Four-Pixel Region Hit Buffer

This block serves one region of four neighbouring pixels in a readout column. Each pixel delivers a discriminator line, and the clock is the bunch-crossing clock. A rising discriminator is a leading edge. All pixels of the region share one timestamp per stored hit, and each pixel keeps its own time-over-threshold (ToT) count. A hit is written into a shallow local buffer tagged with the bunch-crossing timestamp that was present when its leading edge was seen. It waits there until the trigger latency has elapsed.

When a stored hit reaches its latency age, the trigger input is examined in that same cycle. If the trigger is high, the cell is marked for readout. If it is low, the cell is released. Marked cells are offered one at a time on a readout port and are removed by an acknowledge. Hits that find every cell in use are lost, and each such loss is counted. An optional truncation mode stops the ToT count of pixels that are still high when another leading edge arrives in the region.

Top module: `pixreg_buf`

## Requirements
- R1: During and after reset, `rd_valid` is 0, `ovf_cnt` is 0 and every buffer cell is free.
- R2: A leading edge is a sample of 1 on a `disc` bit whose previous sample was 0. Leading edges on several pixels in the same cycle occupy a single cell, which holds one timestamp (the `ts` value of that cycle) and a separate ToT for each pixel. A pixel with no edge in that hit reads ToT 0.
- R3: The buffer has DEPTH cells, numbered 0 to DEPTH-1. A new hit takes the lowest-numbered cell that was free at the start of the cycle.
- R4: A stored cell whose age `ts - stored_ts` (modulo 2^TSW) equals `latency` is marked for readout if `trig` is 1 in that cycle. Otherwise it is freed and never appears on the readout port.
- R5: A pixel's ToT equals the number of consecutive cycles in which `disc` is sampled 1, counting the leading-edge cycle. The count saturates at 15.
- R6: A leading edge that finds no free cell is lost. `ovf_cnt` then rises by one for that cycle, and it saturates at its maximum.
- R7: A leading edge on any pixel is accepted even while other pixels of the region are still counting ToT for an earlier hit. It takes a new cell, and the earlier counts continue.
- R8: With `trunc_en` = 1, a leading edge anywhere in the region ends the ToT count of every other pixel that is still counting. Their ToT keeps the value reached before that cycle.
- R9: `rd_valid` is 1 while any cell is marked. The port then shows the lowest-numbered marked cell: `rd_ts` carries its timestamp and `rd_tot` carries pixel p in bits [4p+3:4p]. `rd_ack` = 1 while `rd_valid` is 1 frees that cell at the next edge.
- R10: A cell that is released in a cycle cannot be reused in that same cycle. A leading edge that arrives in that cycle on a full buffer is counted as an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc | input | NPIX | Discriminator lines, one per pixel |
| ts | input | TSW | Free-running bunch-crossing timestamp |
| latency | input | TSW | Trigger latency in bunch crossings |
| trig | input | 1 | Trigger for the crossing that has reached latency age |
| trunc_en | input | 1 | Enables ToT truncation |
| rd_ack | input | 1 | Removes the entry currently offered for readout |
| rd_valid | output | 1 | A triggered entry is waiting |
| rd_ts | output | TSW | Timestamp of the offered entry |
| rd_tot | output | NPIX*TOTW | Per-pixel ToT of the offered entry |
| ovf_cnt | output | OVFW | Count of hits lost to a full buffer |

## Verification
The assertions rely on several assumptions about the inputs. The timestamp advances by one every clock. The latency is nonzero and stays fixed while any cell is occupied. The block also assumes that a hit ends well before it ages out, although it still handles the case where it does not. The bench increments `ts` once per cycle and changes `latency` only after the buffer has drained. Its directed hits all fall low several cycles before the latency, apart from one saturation case that is timed on purpose to end exactly at the latency. Random traffic runs at a fixed latency of 120 with acknowledges issued freely, including in cycles where nothing is offered.

// File: rtl/pixreg_buf.sv
module pixreg_buf #(
  parameter int NPIX  = 4,
  parameter int DEPTH = 5,
  parameter int TSW   = 8,
  parameter int TOTW  = 4,
  parameter int OVFW  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPIX-1:0]      disc,
  input  logic [TSW-1:0]       ts,
  input  logic [TSW-1:0]       latency,
  input  logic                 trig,
  input  logic                 trunc_en,
  input  logic                 rd_ack,
  output logic                 rd_valid,
  output logic [TSW-1:0]       rd_ts,
  output logic [NPIX*TOTW-1:0] rd_tot,
  output logic [OVFW-1:0]      ovf_cnt
);
  localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [TOTW-1:0] TOTMAX = {TOTW{1'b1}};
  localparam logic [OVFW-1:0] OVFMAX = {OVFW{1'b1}};

  logic [DEPTH-1:0] occ, flg, expire;
  logic [TSW-1:0]   cts  [DEPTH];
  logic [TOTW-1:0]  ctot [DEPTH][NPIX];
  logic [NPIX-1:0]  disc_q, act, le;
  logic [CW-1:0]    ptr  [NPIX];
  logic [CW-1:0]    alloc_idx, out_idx;
  logic             free_found, hit, take;

  assign le   = disc & ~disc_q;
  assign hit  = |le;
  assign take = hit & free_found;

  always_comb begin
    free_found = 1'b0;
    alloc_idx  = '0;
    out_idx    = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      expire[i] = occ[i] & ~flg[i] & ((ts - cts[i]) == latency);
      if (!occ[i]) begin
        free_found = 1'b1;
        alloc_idx  = CW'(i);
      end
      if (flg[i]) out_idx = CW'(i);
    end
  end

  assign rd_valid = |flg;
  assign rd_ts    = cts[out_idx];

  for (genvar p = 0; p < NPIX; p++) begin : g_out
    assign rd_tot[p*TOTW +: TOTW] = ctot[out_idx][p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ     <= '0;
      flg     <= '0;
      disc_q  <= '0;
      act     <= '0;
      ovf_cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        cts[i] <= '0;
        for (int p = 0; p < NPIX; p++) ctot[i][p] <= '0;
      end
      for (int p = 0; p < NPIX; p++) ptr[p] <= '0;
    end else begin
      disc_q <= disc;
      for (int i = 0; i < DEPTH; i++) begin
        if (expire[i]) begin
          if (trig) flg[i] <= 1'b1;
          else      occ[i] <= 1'b0;
        end
      end
      if (rd_ack && rd_valid) begin
        occ[out_idx] <= 1'b0;
        flg[out_idx] <= 1'b0;
      end
      if (take) begin
        occ[alloc_idx] <= 1'b1;
        flg[alloc_idx] <= 1'b0;
        cts[alloc_idx] <= ts;
        for (int p = 0; p < NPIX; p++)
          ctot[alloc_idx][p] <= le[p] ? TOTW'(1) : '0;
      end
      if (hit && !free_found && ovf_cnt != OVFMAX) ovf_cnt <= ovf_cnt + 1'b1;
      for (int p = 0; p < NPIX; p++) begin
        if (le[p]) begin
          act[p] <= take;
          ptr[p] <= alloc_idx;
        end else if (act[p]) begin
          if (!disc[p] || (trunc_en && hit) || expire[ptr[p]])
            act[p] <= 1'b0;
          else if (ctot[ptr[p]][p] != TOTMAX)
            ctot[ptr[p]][p] <= ctot[ptr[p]][p] + 1'b1;
        end
      end
    end
  end

  assert_new_cell_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(occ & ~$past(occ)));

  assert_alloc_needs_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((occ & ~$past(occ)) != '0) |-> $past(|le));

  assert_flag_needs_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(trig));

  assert_ovf_only_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_cnt != $past(ovf_cnt)) |-> ($past(&occ) && $past(|le)));

  assert_trunc_stops_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trunc_en && (|le) && act[0] && !le[0]) |-> !act[0]);
endmodule

// File: tb/pixreg_buf_test.sv
module pixreg_buf_test;
  localparam int PERIOD = 10;
  localparam int NP = 4;
  localparam int DP = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  disc = '0;
  logic [7:0]  ts = '0;
  logic [7:0]  latency = 8'd20;
  logic        trig = 1'b0;
  logic        trunc_en = 1'b0;
  logic        rd_ack = 1'b0;
  logic        rd_valid;
  logic [7:0]  rd_ts;
  logic [15:0] rd_tot;
  logic [7:0]  ovf_cnt;

  int checks = 0;
  int errors = 0;
  int tsv = 0;
  bit done = 0;

  int m_occ[DP], m_flg[DP], m_ts[DP], m_tot[DP][NP], m_exp[DP];
  int m_act[NP], m_ptr[NP], m_dq[NP], m_le[NP];
  int m_ovf, fi, ai, anyle;

  pixreg_buf uut (
    .clk(clk), .rst_n(rst_n), .disc(disc), .ts(ts), .latency(latency),
    .trig(trig), .trunc_en(trunc_en), .rd_ack(rd_ack),
    .rd_valid(rd_valid), .rd_ts(rd_ts), .rd_tot(rd_tot), .ovf_cnt(ovf_cnt)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ovf = 0;
      for (int i = 0; i < DP; i++) begin
        m_occ[i] = 0; m_flg[i] = 0; m_ts[i] = 0;
        for (int p = 0; p < NP; p++) m_tot[i][p] = 0;
      end
      for (int p = 0; p < NP; p++) begin m_act[p] = 0; m_ptr[p] = 0; m_dq[p] = 0; end
    end else begin
      fi = -1; ai = -1; anyle = 0;
      for (int i = DP - 1; i >= 0; i--) begin
        m_exp[i] = (m_occ[i] != 0 && m_flg[i] == 0 &&
                    (((int'(ts) - m_ts[i]) & 255) == int'(latency))) ? 1 : 0;
        if (m_occ[i] == 0) fi = i;
        if (m_flg[i] != 0) ai = i;
      end
      for (int p = 0; p < NP; p++) begin
        m_le[p] = (disc[p] && m_dq[p] == 0) ? 1 : 0;
        if (m_le[p] != 0) anyle = 1;
      end
      for (int p = 0; p < NP; p++) begin
        if (m_le[p] != 0) begin
          m_act[p] = (fi >= 0) ? 1 : 0;
          m_ptr[p] = fi;
        end else if (m_act[p] != 0) begin
          if (!disc[p] || (trunc_en && anyle != 0) || m_exp[m_ptr[p]] != 0) m_act[p] = 0;
          else if (m_tot[m_ptr[p]][p] < 15) m_tot[m_ptr[p]][p]++;
        end
      end
      for (int i = 0; i < DP; i++)
        if (m_exp[i] != 0) begin
          if (trig) m_flg[i] = 1; else m_occ[i] = 0;
        end
      if (rd_ack && ai >= 0) begin m_occ[ai] = 0; m_flg[ai] = 0; end
      if (anyle != 0) begin
        if (fi >= 0) begin
          m_occ[fi] = 1; m_flg[fi] = 0; m_ts[fi] = int'(ts);
          for (int p = 0; p < NP; p++) m_tot[fi][p] = m_le[p];
        end else if (m_ovf < 255) m_ovf++;
      end
      for (int p = 0; p < NP; p++) m_dq[p] = disc[p];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int oi;
      oi = -1;
      for (int i = DP - 1; i >= 0; i--) if (m_flg[i] != 0) oi = i;
      chk("R9 rd_valid", int'(rd_valid), (oi >= 0) ? 1 : 0);
      chk("R6 ovf_cnt", int'(ovf_cnt), m_ovf);
      if (oi >= 0) begin
        chk("R4 rd_ts", int'(rd_ts), m_ts[oi]);
        for (int p = 0; p < NP; p++) chk("R5 rd_tot", int'(rd_tot[p*4 +: 4]), m_tot[oi][p]);
      end
    end
  end

  task automatic cyc(input logic [3:0] d, input logic t, input logic a);
    @(negedge clk);
    disc = d; trig = t; rd_ack = a; ts = tsv[7:0];
    tsv++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(4'b0000, 1'b0, 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int t0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rd_valid in reset", int'(rd_valid), 0);
    chk("R1 ovf_cnt in reset", int'(ovf_cnt), 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 rd_valid after reset", int'(rd_valid), 0);

    // single hit, ToT 3, triggered
    t0 = tsv;
    cyc(4'b0001, 0, 0); cyc(4'b0001, 0, 0); cyc(4'b0001, 0, 0);
    idle(17);
    cyc(4'b0000, 1, 0);
    cyc(4'b0000, 0, 0);
    chk("R4 triggered entry offered", int'(rd_valid), 1);
    chk("R4 stored timestamp", int'(rd_ts), t0 & 255);
    chk("R5 ToT three cycles", int'(rd_tot), 16'h0003);
    cyc(4'b0000, 0, 1);
    cyc(4'b0000, 0, 0);
    chk("R9 ack removes entry", int'(rd_valid), 0);

    // shared cell, separate ToT
    t0 = tsv;
    cyc(4'b0101, 0, 0); cyc(4'b0101, 0, 0);
    cyc(4'b0100, 0, 0); cyc(4'b0100, 0, 0); cyc(4'b0100, 0, 0);
    idle(15);
    cyc(4'b0000, 1, 0);
    cyc(4'b0000, 0, 0);
    chk("R2 shared cell ToT", int'(rd_tot), 16'h0502);
    chk("R2 shared timestamp", int'(rd_ts), t0 & 255);
    cyc(4'b0000, 0, 1);
    idle(2);

    // fill, overflow, same-cycle release
    for (int k = 0; k < 5; k++) begin cyc(4'b0001, 0, 0); cyc(4'b0000, 0, 0); end
    cyc(4'b0001, 0, 0);
    cyc(4'b0000, 0, 0);
    chk("R6 sixth hit lost", int'(ovf_cnt), 1);
    idle(8);
    cyc(4'b0001, 0, 0);
    cyc(4'b0000, 0, 0);
    chk("R10 released cell not reused same cycle", int'(ovf_cnt), 2);
    cyc(4'b0001, 0, 0);
    cyc(4'b0000, 0, 0);
    chk("R3 freed cell reused next cycle", int'(ovf_cnt), 2);
    idle(40);
    chk("R4 untriggered hits discarded", int'(rd_valid), 0);

    // no dead time, then truncation
    for (int tr = 0; tr < 2; tr++) begin
      trunc_en = tr[0];
      cyc(4'b0001, 0, 0); cyc(4'b0001, 0, 0);
      cyc(4'b0011, 0, 0); cyc(4'b0011, 0, 0); cyc(4'b0011, 0, 0); cyc(4'b0011, 0, 0);
      idle(14);
      cyc(4'b0000, 1, 0);
      cyc(4'b0000, 0, 0);
      if (tr == 0) chk("R7 first pixel keeps counting", int'(rd_tot), 16'h0006);
      else chk("R8 truncated ToT", int'(rd_tot), 16'h0002);
      cyc(4'b0000, 1, 0);
      cyc(4'b0000, 0, 1);
      cyc(4'b0000, 0, 0);
      chk("R7 second edge got own cell", int'(rd_tot), 16'h0040);
      cyc(4'b0000, 0, 1);
      cyc(4'b0000, 0, 0);
      chk("R9 both entries drained", int'(rd_valid), 0);
    end
    trunc_en = 1'b0;

    // saturation
    for (int k = 0; k < 20; k++) cyc(4'b1000, 0, 0);
    cyc(4'b0000, 1, 0);
    cyc(4'b0000, 0, 0);
    chk("R5 ToT saturates", int'(rd_tot), 16'hF000);
    cyc(4'b0000, 0, 1);
    idle(25);

    // random traffic at latency 120
    @(negedge clk);
    latency = 8'd120;
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] d;
      for (int p = 0; p < NP; p++)
        d[p] = ($urandom_range(0, 9) < 3) ? ~disc[p] : disc[p];
      if (k % 500 == 0) trunc_en = ~trunc_en;
      cyc(d, ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1));
    end
    for (int k = 0; k < 140; k++) cyc(4'b0000, 0, 1);
    chk("R9 drained after traffic", int'(rd_valid), 0);
    finish_run();
  end

  initial begin
    #(PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule